// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block gathers a bank of level-sensitive interrupt lines and produces two kinds of request for a primary interrupt controller. The first is one combined request, raised while any input that is both active and enabled is present; in a system it feeds a single upper input of the primary controller. The second is a vector of direct-route outputs. Any input in the window 21 to 30 can be routed to the primary-controller line of the same index, and this path bypasses the combined request.

Software drives the block through a word-addressed register port with separate read and write strobes and a 32-bit data path. Enable bits are changed by set and clear words, never by overwriting, so two agents cannot undo each other's work. A soft-interrupt word gives quick control of enable bit 0 and reports raw bit 0. The raw level, the combined request and the direct-route vector are all registered and change on the same clock edge as the input sample or the register write that causes them.

Read responses come from a two-state access machine. `RD_IDLE` waits for a read strobe and then moves to `RD_RESP`, taking the read data with it. `RD_RESP` presents `rd_valid` for one cycle. It stays in `RD_RESP` when a new strobe arrives, and otherwise returns to `RD_IDLE`. Reset forces `RD_IDLE`.

Top module: `sic_passthru`

## Requirements
- R1: A synchronous active-high reset clears the raw level, the enable mask and the route-enable mask, so `raw_lvl`, `comb_irq`, `route_irq` and `rd_valid` are all 0 after reset.
- R2: Each input is sampled every clock. `raw_lvl` shows the input vector from the previous edge, and a read of word 1 returns it.
- R3: A read of word 0 returns raw level AND enable mask. A read of word 2 returns the enable mask.
- R4: A write to word 2 ORs the write data into the enable mask. A write to word 3 clears every enable bit that is 1 in the write data.
- R5: A read of word 4 returns raw bit 0 in bit 0, with all other bits 0. A nonzero write to word 4 sets enable bit 0, and a nonzero write to word 5 clears it. A zero write to either word leaves the mask unchanged.
- R6: A write to word 8 ORs in only the bits 21 to 30 of the data (data AND 0x7FE00000). A write to word 9 clears the route-enable bits that are 1 in the data. A read of word 8 returns the route-enable mask.
- R7: `route_irq` equals raw level AND route-enable mask, so route-disabled bits are 0. The enable mask has no effect on it.
- R8: `comb_irq` is 1 exactly when raw level AND enable mask is nonzero. It updates on the same edge as the input sample or the write that changes either term.
- R9: `rd_valid` is 1 in the cycle after a cycle with `rd_en` high and 0 otherwise. `rd_data` holds the value of the addressed word before any same-cycle write.
- R10: Reads of words 6, 7 and 10 to 15 return 0. Writes to those words change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| addr | input | 4 | Word address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response flag |
| raw_lvl | output | 32 | Registered raw input levels |
| comb_irq | output | 1 | Combined masked request |
| route_irq | output | 32 | Direct-route outputs, nonzero only in bits 21 to 30 |

## Verification
Some relations hold on every cycle, and the assertions check those. `comb_irq` must agree with the registered raw level and enable mask, and `route_irq` must equal raw level AND route enable. No route-enable bit may exist outside bits 21 to 30. `rd_valid` must follow the read strobe by one cycle, and a write to an unlisted word must leave both masks unchanged. Other properties depend on register semantics and only the bench scenarios can show them. These are the set/clear arithmetic of the enable words, the zero-write rule of the soft-interrupt words, the 0x7FE00000 filter on route-enable sets, the read values of each word, and zero reads from unlisted words.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int SIC_ADDR_W = 4;

    typedef enum logic [SIC_ADDR_W-1:0] {
        WORD_STATUS  = 4'd0,
        WORD_RAW     = 4'd1,
        WORD_EN      = 4'd2,
        WORD_ENCLR   = 4'd3,
        WORD_SOFT    = 4'd4,
        WORD_SOFTCLR = 4'd5,
        WORD_ROUTE   = 4'd8,
        WORD_RTCLR   = 4'd9
    } sic_word_e;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } sic_rd_state_e;

    // Build a mask with ones from bit lo to bit hi inclusive.
    function automatic logic [31:0] span_mask(input int lo, input int hi);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int N_IRQ    = 32,
    parameter int ROUTE_LO = 21,
    parameter int ROUTE_HI = 30
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_IRQ-1:0]      irq_in,
    input  logic [SIC_ADDR_W-1:0] addr,
    input  logic                  wr_en,
    input  logic [N_IRQ-1:0]      wr_data,
    output logic [N_IRQ-1:0]      level_q,
    output logic [N_IRQ-1:0]      en_q,
    output logic [N_IRQ-1:0]      route_q,
    output logic [N_IRQ-1:0]      level_d,
    output logic [N_IRQ-1:0]      en_d,
    output logic [N_IRQ-1:0]      route_d
);
    localparam logic [31:0] ROUTE_SPAN = span_mask(ROUTE_LO, ROUTE_HI);
    localparam logic [N_IRQ-1:0] ROUTE_OK = ROUTE_SPAN[N_IRQ-1:0];
    localparam logic [N_IRQ-1:0] BIT0 = {{(N_IRQ-1){1'b0}}, 1'b1};

    logic data_nz;
    assign data_nz = |wr_data;
    assign level_d = irq_in;

    always_comb begin
        en_d    = en_q;
        route_d = route_q;
        if (wr_en) begin
            unique case (addr)
                WORD_EN:      en_d    = en_q | wr_data;
                WORD_ENCLR:   en_d    = en_q & ~wr_data;
                WORD_SOFT:    if (data_nz) en_d = en_q | BIT0;
                WORD_SOFTCLR: if (data_nz) en_d = en_q & ~BIT0;
                WORD_ROUTE:   route_d = route_q | (wr_data & ROUTE_OK);
                WORD_RTCLR:   route_d = route_q & ~wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            en_q    <= '0;
            route_q <= '0;
        end else begin
            level_q <= level_d;
            en_q    <= en_d;
            route_q <= route_d;
        end
    end

    assert_route_span_R6: assert property (@(posedge clk) disable iff (rst)
        (route_q & ~ROUTE_OK) == '0);

    assert_unlisted_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr inside {4'd6, 4'd7, [4'd10:4'd15]}))
            |=> ($stable(en_q) && $stable(route_q)));
endmodule

// File: rtl/sic_outs.sv
module sic_outs #(
    parameter int N_IRQ = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] level_d,
    input  logic [N_IRQ-1:0] en_d,
    input  logic [N_IRQ-1:0] route_d,
    input  logic [N_IRQ-1:0] level_q,
    input  logic [N_IRQ-1:0] en_q,
    input  logic [N_IRQ-1:0] route_q,
    output logic             comb_irq,
    output logic [N_IRQ-1:0] route_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            comb_irq  <= 1'b0;
            route_irq <= '0;
        end else begin
            comb_irq  <= |(level_d & en_d);
            route_irq <= level_d & route_d;
        end
    end

    assert_comb_tracks_R8: assert property (@(posedge clk) disable iff (rst)
        comb_irq == (|(level_q & en_q)));

    assert_route_tracks_R7: assert property (@(posedge clk) disable iff (rst)
        route_irq == (level_q & route_q));
endmodule

// File: rtl/sic_rdport.sv
module sic_rdport
    import sic_pkg::*;
#(
    parameter int N_IRQ = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [SIC_ADDR_W-1:0] addr,
    input  logic [N_IRQ-1:0]      level_q,
    input  logic [N_IRQ-1:0]      en_q,
    input  logic [N_IRQ-1:0]      route_q,
    output logic [N_IRQ-1:0]      rd_data,
    output logic                  rd_valid
);
    sic_rd_state_e state_q, state_d;
    logic [N_IRQ-1:0] sel_word, data_q;

    always_comb begin
        sel_word = '0;
        unique case (addr)
            WORD_STATUS: sel_word = level_q & en_q;
            WORD_RAW:    sel_word = level_q;
            WORD_EN:     sel_word = en_q;
            WORD_SOFT:   sel_word = {{(N_IRQ-1){1'b0}}, level_q[0]};
            WORD_ROUTE:  sel_word = route_q;
            default:     sel_word = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_en) state_d = RD_RESP;
            RD_RESP: if (!rd_en) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) data_q <= sel_word;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RD_IDLE: ;
            RD_RESP: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            default: ;
        endcase
    end

    assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_rvalid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/sic_passthru.sv
module sic_passthru
    import sic_pkg::*;
#(
    parameter int N_IRQ    = 32,
    parameter int ROUTE_LO = 21,
    parameter int ROUTE_HI = 30
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_IRQ-1:0]      irq_in,
    input  logic [SIC_ADDR_W-1:0] addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [N_IRQ-1:0]      wr_data,
    output logic [N_IRQ-1:0]      rd_data,
    output logic                  rd_valid,
    output logic [N_IRQ-1:0]      raw_lvl,
    output logic                  comb_irq,
    output logic [N_IRQ-1:0]      route_irq
);
    logic [N_IRQ-1:0] level_q, en_q, route_q, level_d, en_d, route_d;

    sic_regs #(.N_IRQ(N_IRQ), .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI)) u_regs (
        .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .level_q(level_q), .en_q(en_q), .route_q(route_q),
        .level_d(level_d), .en_d(en_d), .route_d(route_d)
    );

    sic_outs #(.N_IRQ(N_IRQ)) u_outs (
        .clk(clk), .rst(rst), .level_d(level_d), .en_d(en_d), .route_d(route_d),
        .level_q(level_q), .en_q(en_q), .route_q(route_q),
        .comb_irq(comb_irq), .route_irq(route_irq)
    );

    sic_rdport #(.N_IRQ(N_IRQ)) u_rdport (
        .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .level_q(level_q),
        .en_q(en_q), .route_q(route_q), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign raw_lvl = level_q;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (raw_lvl == '0 && !comb_irq && route_irq == '0 && !rd_valid));
endmodule

// File: tb/sic_passthru_bench.sv
`timescale 1ns/1ps
module sic_passthru_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [31:0] raw_lvl;
    logic        comb_irq;
    logic [31:0] route_irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    sic_passthru u_sic_passthru (
        .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .raw_lvl(raw_lvl), .comb_irq(comb_irq), .route_irq(route_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 rd_valid on response", {31'b0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    task automatic set_irq(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 raw_lvl", raw_lvl, 32'h0);
        chk("R1 comb_irq", {31'b0, comb_irq}, 32'h0);
        chk("R1 route_irq", route_irq, 32'h0);
        chk("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
        bus_rd(4'd2, d); chk("R1 enable mask", d, 32'h0);
        bus_rd(4'd8, d); chk("R1 route mask", d, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        set_irq(32'hA5A5_0003);
        chk("R2 raw_lvl", raw_lvl, 32'hA5A5_0003);
        bus_rd(4'd1, d); chk("R2 raw word", d, 32'hA5A5_0003);
        bus_rd(4'd0, d); chk("R3 status masked off", d, 32'h0);
        chk("R8 comb idle", {31'b0, comb_irq}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_wr(4'd2, 32'h0000_0F01);
        chk("R8 comb after enable", {31'b0, comb_irq}, 32'h1);
        bus_rd(4'd2, d); chk("R3 enable read", d, 32'h0000_0F01);
        bus_rd(4'd0, d); chk("R3 status", d, 32'h0000_0001);
        bus_wr(4'd3, 32'h0000_0001);
        chk("R8 comb after clear", {31'b0, comb_irq}, 32'h0);
        bus_rd(4'd2, d); chk("R4 clear one bit", d, 32'h0000_0F00);
        bus_wr(4'd2, 32'h0000_0100);
        bus_rd(4'd2, d); chk("R4 set is OR", d, 32'h0000_0F00);
        set_irq(32'h0000_0200);
        chk("R8 comb on input rise", {31'b0, comb_irq}, 32'h1);
        bus_rd(4'd0, d); chk("R3 status bit 9", d, 32'h0000_0200);
        set_irq(32'h0);
        chk("R8 comb on input fall", {31'b0, comb_irq}, 32'h0);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        set_irq(32'h0000_0021);
        bus_rd(4'd4, d); chk("R5 soft read bit0", d, 32'h1);
        bus_wr(4'd4, 32'h0);
        bus_rd(4'd2, d); chk("R5 zero set ignored", d, 32'h0000_0F00);
        chk("R5 comb unchanged", {31'b0, comb_irq}, 32'h0);
        bus_wr(4'd4, 32'h8000_0000);
        bus_rd(4'd2, d); chk("R5 nonzero set", d, 32'h0000_0F01);
        chk("R5 comb after soft set", {31'b0, comb_irq}, 32'h1);
        bus_wr(4'd5, 32'h0);
        bus_rd(4'd2, d); chk("R5 zero clear ignored", d, 32'h0000_0F01);
        bus_wr(4'd5, 32'h2);
        bus_rd(4'd2, d); chk("R5 nonzero clear", d, 32'h0000_0F00);
        chk("R5 comb after soft clear", {31'b0, comb_irq}, 32'h0);
        set_irq(32'h0000_0020);
        bus_rd(4'd4, d); chk("R5 soft read only bit0", d, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        bus_wr(4'd8, 32'hFFFF_FFFF);
        bus_rd(4'd8, d); chk("R6 set filtered", d, 32'h7FE0_0000);
        set_irq(32'hFFFF_FFFF);
        chk("R7 route all", route_irq, 32'h7FE0_0000);
        bus_wr(4'd9, 32'h0020_0000);
        chk("R7 route after clear", route_irq, 32'h7FC0_0000);
        bus_rd(4'd8, d); chk("R6 clear bit 21", d, 32'h7FC0_0000);
        bus_wr(4'd3, 32'hFFFF_FFFF);
        set_irq(32'h4000_0000);
        chk("R7 route ignores enable", route_irq, 32'h4000_0000);
        chk("R8 comb bypassed", {31'b0, comb_irq}, 32'h0);
        set_irq(32'h0);
        chk("R7 route falls", route_irq, 32'h0);
    endtask

    task automatic t_unlisted();
        logic [31:0] d;
        bus_wr(4'd2, 32'h0000_00F0);
        bus_rd(4'd6, d);  chk("R10 read word 6", d, 32'h0);
        bus_rd(4'd7, d);  chk("R10 read word 7", d, 32'h0);
        bus_rd(4'd10, d); chk("R10 read word 10", d, 32'h0);
        bus_rd(4'd15, d); chk("R10 read word 15", d, 32'h0);
        bus_wr(4'd6, 32'hFFFF_FFFF);
        bus_wr(4'd11, 32'hFFFF_FFFF);
        bus_rd(4'd2, d); chk("R10 enable untouched", d, 32'h0000_00F0);
        bus_rd(4'd8, d); chk("R10 route untouched", d, 32'h7FC0_0000);
    endtask

    task automatic t_rdtiming();
        @(negedge clk);
        chk("R9 idle valid low", {31'b0, rd_valid}, 32'h0);
        addr = 4'd2; rd_en = 1'b1;
        @(negedge clk);
        chk("R9 valid first", {31'b0, rd_valid}, 32'h1);
        addr = 4'd8;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 back-to-back valid", {31'b0, rd_valid}, 32'h1);
        chk("R9 back-to-back data", rd_data, 32'h7FC0_0000);
        @(negedge clk);
        chk("R9 valid drops", {31'b0, rd_valid}, 32'h0);
        // Read and write in one cycle: the response carries the old value.
        addr = 4'd2; rd_en = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_0001;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R9 read before write", rd_data, 32'h0000_00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_raw();
        t_enable();
        t_soft();
        t_route();
        t_unlisted();
        t_rdtiming();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule